// File: doc/BRIEF.md
# Configurable Logic Cell Pair

This block is one pin-driving logic cell and one buried logic cell, paired to share a single pad. Each cell takes a sum-of-products term. It can flip that term's polarity. It then passes the term either straight through or through a storage element. Static configuration inputs choose the element: a D flip-flop, a toggle flip-flop, or a level-sensitive latch. The element is timed by one of two global clocks. Per-cell clear and preset inputs override the element. Clear wins when both are asserted.

The global clocks are sampled by the system clock `clk`. A rising edge of the selected global clock is the edge seen at a `clk` edge, and stored results update on that same `clk` edge. Clear and preset also act on the next `clk` edge, whatever the global clocks are doing. The pin cell drives the pad output and passes the pad enable through. It also returns its own value on a feedback output that is independent of the pad, so the pad can act as an input while the cell stays in use. The buried cell always drives its own feedback output. It can be set to capture the pad input instead of its own term, either as an input register or as an input latch.

Top module: `pldm_pair`

## Requirements
- R1: While `rst_n` is low, every storage element is cleared at once. A cell in a stored mode then shows 0 on its feedback, and the pin cell shows 0 on `pad_o`.
- R2: When the mode field is 00 (bypass), the cell output equals the sum-of-products term XOR the invert bit in the same cycle. No clock is needed.
- R3: When the invert bit is 1, the term is inverted before the bypass path and before every storage element.
- R4: In mode 01 (D flip-flop), the cell loads the post-polarity term at the `clk` edge that sees a rising edge of the selected global clock. At every other edge it holds its value.
- R5: In mode 10 (toggle flip-flop), the cell inverts its state at a selected-clock rising edge when the post-polarity term is 1. When the term is 0 it holds.
- R6: In mode 11 (latch), the cell output follows the post-polarity term while the selected global clock is high. The element keeps the last value it held while that clock was high, and it holds that value while the clock is low.
- R7: A select value of 0 picks `gclk_i[0]` and a select value of 1 picks `gclk_i[1]`. Edges and levels on the clock that is not selected have no effect.
- R8: A clear forces the element to 0 and a preset forces it to 1, on the next `clk` edge, whatever the global clocks are doing. Clear wins when both are asserted.
- R9: `pad_oe_o` equals `pin_oe_i`. `pad_o` carries the pin cell's output. `pin_fb_o` carries the same value whether or not the pad is enabled.
- R10: With `bur_capture_i` set to 1, the buried cell takes its data from `pad_i`. Mode 11 makes it an input latch. Every other mode, including 10, makes it a D input register.
- R11: `bur_fb_o` always carries the buried cell's output. With capture off, the buried cell uses `bur_sop_i` as its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the global clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| gclk_i | input | NUM_GCLK (2) | Global clocks; also serve as latch enables |
| pin_mode_i | input | 2 | Pin cell mode: 00 bypass, 01 D, 10 toggle, 11 latch |
| pin_inv_i | input | 1 | Pin cell polarity invert |
| pin_gsel_i | input | GSEL_W (1) | Pin cell global clock select |
| pin_sop_i | input | 1 | Pin cell sum-of-products term |
| pin_clr_i | input | 1 | Pin cell clear |
| pin_set_i | input | 1 | Pin cell preset |
| pin_oe_i | input | 1 | Pad output enable request |
| bur_mode_i | input | 2 | Buried cell mode, same encoding |
| bur_inv_i | input | 1 | Buried cell polarity invert |
| bur_gsel_i | input | GSEL_W (1) | Buried cell global clock select |
| bur_sop_i | input | 1 | Buried cell sum-of-products term |
| bur_clr_i | input | 1 | Buried cell clear |
| bur_set_i | input | 1 | Buried cell preset |
| bur_capture_i | input | 1 | Buried cell takes its data from the pad |
| pad_i | input | 1 | Value seen on the shared pad |
| pad_o | output | 1 | Value driven to the pad |
| pad_oe_o | output | 1 | Pad driver enable (0 means high impedance) |
| pin_fb_o | output | 1 | Pin cell feedback |
| bur_fb_o | output | 1 | Buried cell feedback |

## Verification
Bypass outputs and open latches are due in the same cycle as their inputs. D, toggle, capture, clear and preset results appear after the first `clk` edge that sees the input or the selected-clock rise. System reset takes effect immediately. The bench changes its inputs 1 ns after a rising `clk` edge. It checks each result 1 ns after the next rising edge, so exactly one register stage lies between stimulus and check. A same-cycle result is checked at that same point, with its inputs still steady. The vector table carries cell state from one row to the next, so the expected values for hold, toggle and clock-select behaviour were worked out row by row.

// File: rtl/pldm_pkg.sv
package pldm_pkg;
    localparam int NUM_GCLK = 2;
    localparam int GSEL_W   = (NUM_GCLK > 1) ? $clog2(NUM_GCLK) : 1;

    typedef enum logic [1:0] {
        MODE_COMB  = 2'b00,
        MODE_DFF   = 2'b01,
        MODE_TFF   = 2'b10,
        MODE_LATCH = 2'b11
    } pldm_mode_e;

    typedef struct packed {
        logic state;
    } store_s;

    typedef struct packed {
        logic [NUM_GCLK-1:0] prev;
    } edge_s;
endpackage

// File: rtl/pldm_gclk_edge.sv
module pldm_gclk_edge
    import pldm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GCLK-1:0] gclk_i,
    output logic [NUM_GCLK-1:0] rise_o
);
    edge_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = gclk_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // one rise detector per global clock
    for (genvar g = 0; g < NUM_GCLK; g++) begin : g_rise
        assign rise_o[g] = gclk_i[g] & ~st_q.prev[g];
    end
endmodule

// File: rtl/pldm_store.sv
module pldm_store
    import pldm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pldm_mode_e mode_i,
    input  logic       inv_i,
    input  logic       d_i,
    input  logic       en_i,
    input  logic       rise_i,
    input  logic       clr_i,
    input  logic       set_i,
    output logic       state_o,
    output logic       out_o
);
    store_s st_d, st_q;
    logic   d_pol;

    always_comb begin
        d_pol = d_i ^ inv_i;
        st_d  = st_q;
        if (clr_i) begin
            st_d.state = 1'b0;
        end else if (set_i) begin
            st_d.state = 1'b1;
        end else begin
            unique case (mode_i)
                MODE_DFF:   if (rise_i) st_d.state = d_pol;
                MODE_TFF:   if (rise_i) st_d.state = st_q.state ^ d_pol;
                MODE_LATCH: if (en_i)   st_d.state = d_pol;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (mode_i == MODE_COMB)
            out_o = d_pol;
        else if (mode_i == MODE_LATCH && en_i && !clr_i && !set_i)
            out_o = d_pol;
        else
            out_o = st_q.state;
    end

    assign state_o = st_q.state;
endmodule

// File: rtl/pldm_pair.sv
module pldm_pair
    import pldm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_GCLK-1:0] gclk_i,
    input  logic [1:0]          pin_mode_i,
    input  logic                pin_inv_i,
    input  logic [GSEL_W-1:0]   pin_gsel_i,
    input  logic                pin_sop_i,
    input  logic                pin_clr_i,
    input  logic                pin_set_i,
    input  logic                pin_oe_i,
    input  logic [1:0]          bur_mode_i,
    input  logic                bur_inv_i,
    input  logic [GSEL_W-1:0]   bur_gsel_i,
    input  logic                bur_sop_i,
    input  logic                bur_clr_i,
    input  logic                bur_set_i,
    input  logic                bur_capture_i,
    input  logic                pad_i,
    output logic                pad_o,
    output logic                pad_oe_o,
    output logic                pin_fb_o,
    output logic                bur_fb_o
);
    logic [NUM_GCLK-1:0] rise;
    pldm_mode_e          bur_mode;
    logic                bur_data;
    logic                pin_out;
    logic                pin_state;
    logic                bur_state;

    pldm_gclk_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .gclk_i (gclk_i),
        .rise_o (rise)
    );

    // capture turns the buried cell into a D register or latch fed by the pad
    always_comb begin
        bur_data = bur_capture_i ? pad_i : bur_sop_i;
        bur_mode = pldm_mode_e'(bur_mode_i);
        if (bur_capture_i && bur_mode != MODE_LATCH)
            bur_mode = MODE_DFF;
    end

    pldm_store u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (pldm_mode_e'(pin_mode_i)),
        .inv_i   (pin_inv_i),
        .d_i     (pin_sop_i),
        .en_i    (gclk_i[pin_gsel_i]),
        .rise_i  (rise[pin_gsel_i]),
        .clr_i   (pin_clr_i),
        .set_i   (pin_set_i),
        .state_o (pin_state),
        .out_o   (pin_out)
    );

    pldm_store u_bur (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (bur_mode),
        .inv_i   (bur_inv_i),
        .d_i     (bur_data),
        .en_i    (gclk_i[bur_gsel_i]),
        .rise_i  (rise[bur_gsel_i]),
        .clr_i   (bur_clr_i),
        .set_i   (bur_set_i),
        .state_o (bur_state),
        .out_o   (bur_fb_o)
    );

    assign pad_o    = pin_out;
    assign pad_oe_o = pin_oe_i;
    assign pin_fb_o = pin_out;

    logic unused_state;
    assign unused_state = pin_state ^ bur_state;
endmodule

// File: rtl/pldm_store_chk.sv
module pldm_store_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       inv_i,
    input logic       d_i,
    input logic       en_i,
    input logic       rise_i,
    input logic       clr_i,
    input logic       set_i,
    input logic       state_o
);
    assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !state_o);

    assert_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> state_o);

    assert_d_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && mode_i == 2'b01 && rise_i)
        |=> state_o == $past(d_i ^ inv_i));

    assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && (mode_i == 2'b01 || mode_i == 2'b10) && !rise_i)
        |=> $stable(state_o));

    assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && mode_i == 2'b10 && rise_i)
        |=> state_o == ($past(state_o) ^ $past(d_i ^ inv_i)));

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i && mode_i == 2'b11 && !en_i) |=> $stable(state_o));
endmodule

bind pldm_store pldm_store_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .inv_i   (inv_i),
    .d_i     (d_i),
    .en_i    (en_i),
    .rise_i  (rise_i),
    .clr_i   (clr_i),
    .set_i   (set_i),
    .state_o (state_o)
);

// File: tb/pldm_pair_tb.sv
module pldm_pair_tb;
    import pldm_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [NUM_GCLK-1:0] gclk;
    logic [1:0]          pin_mode, bur_mode;
    logic                pin_inv, pin_sop, pin_clr, pin_set, pin_oe;
    logic [GSEL_W-1:0]   pin_gsel, bur_gsel;
    logic                bur_inv, bur_sop, bur_clr, bur_set, bur_cap;
    logic                pad_in;
    logic                pad_o, pad_oe, pin_fb, bur_fb;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pldm_pair u_dut (
        .clk (clk), .rst_n (rst_n), .gclk_i (gclk),
        .pin_mode_i (pin_mode), .pin_inv_i (pin_inv), .pin_gsel_i (pin_gsel),
        .pin_sop_i (pin_sop), .pin_clr_i (pin_clr), .pin_set_i (pin_set),
        .pin_oe_i (pin_oe),
        .bur_mode_i (bur_mode), .bur_inv_i (bur_inv), .bur_gsel_i (bur_gsel),
        .bur_sop_i (bur_sop), .bur_clr_i (bur_clr), .bur_set_i (bur_set),
        .bur_capture_i (bur_cap), .pad_i (pad_in),
        .pad_o (pad_o), .pad_oe_o (pad_oe), .pin_fb_o (pin_fb), .bur_fb_o (bur_fb)
    );

    // {mode[9:8], inv[7], gsel[6], sop[5], g1[4], g0[3], clr[2], set[1], expected[0]}
    localparam logic [9:0] VEC [26] = '{
        10'b01_0_0_1_0_0_0_0_0, 10'b01_0_0_1_0_1_0_0_1, 10'b01_0_0_0_0_1_0_0_1,
        10'b01_0_0_0_0_0_0_0_1, 10'b01_0_0_0_0_1_0_0_0, 10'b01_1_0_0_0_0_0_0_0,
        10'b01_1_0_0_0_1_0_0_1, 10'b01_0_1_0_0_0_0_0_1, 10'b01_0_1_0_0_1_0_0_1,
        10'b01_0_1_0_1_1_0_0_0, 10'b10_0_1_1_0_0_0_0_0, 10'b10_0_1_1_1_0_0_0_1,
        10'b10_0_1_1_0_0_0_0_1, 10'b10_0_1_1_1_0_0_0_0, 10'b10_0_1_0_0_0_0_0_0,
        10'b10_0_1_0_1_0_0_0_0, 10'b11_0_0_1_0_1_0_0_1, 10'b11_0_0_0_0_1_0_0_0,
        10'b11_0_0_1_0_0_0_0_0, 10'b11_0_1_1_0_1_0_0_0, 10'b00_0_0_1_0_0_0_0_1,
        10'b00_1_0_1_0_0_0_0_0, 10'b01_0_0_0_0_0_0_1_1, 10'b01_0_0_0_0_0_1_1_0,
        10'b01_0_0_0_0_1_0_1_1, 10'b01_0_0_1_0_0_0_0_1
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    function automatic string vec_tag(input logic [9:0] v);
        if (v[2] || v[1])       return "R8 clear/preset";
        if (v[9:8] == 2'b00)    return "R2 bypass";
        if (v[9:8] == 2'b10)    return "R5 toggle";
        if (v[9:8] == 2'b11)    return "R6 latch";
        if (v[7])               return "R3 invert";
        if (v[6])               return "R7 clock select";
        return "R4 d-register";
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired before the run ended");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; gclk = '0;
        pin_mode = 2'b01; pin_inv = 0; pin_gsel = '0; pin_sop = 0;
        pin_clr = 0; pin_set = 0; pin_oe = 1;
        bur_mode = 2'b01; bur_inv = 0; bur_gsel = '0; bur_sop = 0;
        bur_clr = 0; bur_set = 0; bur_cap = 0; pad_in = 0;
        tick(); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk("R1 pin_fb after reset", pin_fb, 1'b0);
        chk("R1 bur_fb after reset", bur_fb, 1'b0);
        chk("R1 pad_o after reset", pad_o, 1'b0);
        chk("R9 pad_oe follows request", pad_oe, 1'b1);

        // pin cell vector walk; the state carries from row to row
        for (int i = 0; i < 26; i++) begin
            pin_mode = VEC[i][9:8];
            pin_inv  = VEC[i][7];
            pin_gsel = GSEL_W'(VEC[i][6]);
            pin_sop  = VEC[i][5];
            gclk     = {VEC[i][4], VEC[i][3]};
            pin_clr  = VEC[i][2];
            pin_set  = VEC[i][1];
            tick();
            chk($sformatf("%s row %0d pin_fb", vec_tag(VEC[i]), i), pin_fb, VEC[i][0]);
            chk($sformatf("R9 row %0d pad_o", i), pad_o, VEC[i][0]);
        end

        // R9: pad disabled, feedback unaffected (pin state is 1)
        pin_oe = 0; gclk = '0;
        tick();
        chk("R9 pad_oe low", pad_oe, 1'b0);
        chk("R9 pin_fb kept with pad off", pin_fb, 1'b1);

        // R10: input register from the pad
        bur_cap = 1; bur_mode = 2'b01; pad_in = 1; bur_sop = 0;
        tick();
        chk("R10 no capture without edge", bur_fb, 1'b0);
        gclk = 2'b01;
        tick();
        chk("R10 d capture of pad", bur_fb, 1'b1);
        // R10: toggle setting still captures as D
        bur_mode = 2'b10; pad_in = 0; gclk = '0;
        tick();
        gclk = 2'b01;
        tick();
        chk("R10 toggle setting acts as d capture", bur_fb, 1'b0);
        // R10: input latch
        bur_mode = 2'b11; pad_in = 1; gclk = 2'b01;
        tick();
        chk("R10 input latch open", bur_fb, 1'b1);
        pad_in = 0;
        tick();
        chk("R10 input latch follows", bur_fb, 1'b0);
        gclk = '0; pad_in = 1;
        tick();
        chk("R10 input latch closed holds", bur_fb, 1'b0);

        // R11: buried cell on its own term
        bur_cap = 0; bur_mode = 2'b01; bur_sop = 1; pad_in = 0;
        tick();
        gclk = 2'b01;
        tick();
        chk("R11 buried d from own term", bur_fb, 1'b1);
        bur_clr = 1; gclk = '0;
        tick();
        chk("R8 buried clear", bur_fb, 1'b0);
        bur_clr = 0;

        // R1: reset applied mid-run acts at once
        pin_mode = 2'b01; pin_clr = 0; pin_set = 1;
        tick();
        chk("R8 pin preset before reset", pin_fb, 1'b1);
        pin_set = 0;
        tick();
        rst_n = 0;
        #1;
        chk("R1 reset clears at once", pin_fb, 1'b0);
        tick();
        rst_n = 1;
        tick();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule